// File: doc/BRIEF.md
# Sequenced-Feed Watchdog Timer

This block is a register-mapped watchdog that a processor must service at regular intervals. Its clock is divided by four and each divided tick lowers a 24-bit down-counter. Software places a reload value in a limit register. The counter restarts from that value only when the processor writes two specific bytes to the service register, one after the other. If the counter reaches zero, the block raises a sticky timeout flag. If reset is enabled, it also requests a one-cycle system reset.

The control bits can only be set. Once they are set, only a system reset clears them, so runaway code cannot switch the watchdog off. A service attempt that starts correctly but ends with the wrong byte counts as tampering. When the watchdog is running with reset enabled, such an attempt requests a reset at once. Software can read the live counter to work out how much time is left.

Top module: `wdt_seqfeed`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0, the limit register (0x4) reads 0xFFFFFF, the counter register (0xC) reads 0xFFFFFF, and both `irq_timeout` and `sys_reset_req` are low.
- R2: A write to the limit register keeps the low 24 bits of the write data. A value below 0xFF is stored as 0xFF.
- R3: Writing 1 to control bit 0 (run enable) or bit 1 (reset enable) sets that bit. Writing 0 does not clear it; only a reset clears it.
- R4: A valid service is a write to the service register (0x8) whose low byte is 0xAA, followed by a service write whose low byte is 0x55. Other register accesses may fall between the two writes. A valid service reloads the counter from the limit register and sets the armed bit (control bit 3), but only while run enable is set. Without run enable it changes nothing.
- R5: While armed, the counter drops by one every 4 clocks. The first decrement comes 4 clocks after the reload.
- R6: The expiry takes place exactly 4×(limit+1) clocks after the edge that completed the service. At that edge the sticky expired bit (control bit 2) and `irq_timeout` rise, the armed bit clears, and the counter stays at 0.
- R7: At expiry with reset enable set, `sys_reset_req` is high for exactly one cycle. Without reset enable it stays low.
- R8: After a 0xAA, a service write with any other low byte cancels the sequence. While run enable and reset enable are both set, this requests a one-cycle reset in the next cycle, and it never reloads the counter. A service write other than 0xAA while no sequence is pending is ignored.
- R9: When a valid service completes on the same edge as an expiry would occur, the reload wins. No flag is raised and no reset is requested.
- R10: `bus_rdata` shows the addressed register during a read access and is 0 otherwise. Writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq_timeout | output | 1 | Sticky expiry flag |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Two events can land on the same edge: the counter expiring on its final tick, and a valid service reloading it. The bench finds that edge from the limit value it wrote. It times the closing 0x55 write to land exactly on the expiry edge. It then requires that the flag and the reset request stay low and that the counter reads back the full limit. A second, unhindered expiry must then arrive a full period later.

// File: rtl/wdt_seqfeed_pkg.sv
// Package: shared register indices, control bit positions and the state
// type of the service-sequence tracker for the sequenced-feed watchdog.
package wdt_seqfeed_pkg;

    // Word index of each register (byte offset divided by 4)
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LIMIT = 2'd1,
        REG_SERVE = 2'd2,
        REG_COUNT = 2'd3
    } wdt_reg_e;

    // Control register bit positions
    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RSTEN_BIT   = 1;
    localparam int CTRL_EXPIRED_BIT = 2;
    localparam int CTRL_ARMED_BIT   = 3;

    // Service sequence tracker states
    typedef enum logic {
        SEQ_IDLE    = 1'b0,
        SEQ_PENDING = 1'b1
    } seq_state_e;

endpackage

// File: rtl/wdt_feed_seq.sv
// Module: wdt_feed_seq
// Follows service-register writes and decides whether a two-byte sequence
// was valid or broken. A first-magic write while idle opens the sequence.
// The next service write closes it: with the second magic it is valid,
// with anything else it is broken. Non-magic writes while idle are ignored.
// Assumes wr_stb is a single-cycle strobe per service write.
module wdt_feed_seq
    import wdt_seqfeed_pkg::*;
#(
    parameter int          MAGIC_W      = 8,
    parameter logic [7:0]  MAGIC_FIRST  = 8'hAA,
    parameter logic [7:0]  MAGIC_SECOND = 8'h55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [MAGIC_W-1:0] wr_val,
    output logic               seq_ok,
    output logic               seq_bad
);

    localparam logic [MAGIC_W-1:0] FIRST_V  = MAGIC_W'(MAGIC_FIRST);
    localparam logic [MAGIC_W-1:0] SECOND_V = MAGIC_W'(MAGIC_SECOND);

    seq_state_e state_q;

    // Classify a closing write of a pending sequence
    always_comb begin
        seq_ok  = wr_stb && (state_q == SEQ_PENDING) && (wr_val == SECOND_V);
        seq_bad = wr_stb && (state_q == SEQ_PENDING) && (wr_val != SECOND_V);
    end

    // Track whether a first magic value is waiting for its partner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else if (wr_stb) begin
            if (state_q == SEQ_IDLE && wr_val == FIRST_V) begin
                state_q <= SEQ_PENDING;
            end else begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    // A first magic while idle opens a sequence (R4)
    assert_open_on_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && state_q == SEQ_IDLE && wr_val == FIRST_V) |=> (state_q == SEQ_PENDING));

    // A broken sequence always falls back to idle (R8)
    assert_bad_returns_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_bad |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Fixed clock divider. While run is high it gives a one-cycle tick once
// every DIV clocks. Restart puts the phase back to zero, so the first tick
// comes DIV clocks after the restart edge.
module wdt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = run && !restart;
        end else begin : g_divider
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase_q;

            // Tick on the final phase of each divided period
            assign tick = run && !restart && (phase_q == LAST);

            // Advance the phase counter while running
            always_ff @(posedge clk) begin
                if (!rst_n || restart || !run) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            // Ticks never fall on adjacent cycles (R5)
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// Down-counter of the watchdog. A load sets the counter and arms it. Each
// tick while armed takes away one. A tick that finds zero is an expiry: it
// disarms the counter and leaves it at zero. A load on the same edge beats
// the expiry. Assumes tick comes from a prescaler restarted by the same load.
module wdt_countdown #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         armed,
    output logic         expire
);

    // Expiry only when armed, ticking at zero and not being reloaded
    assign expire = armed && tick && (count == '0) && !load;

    // Load, decrement, or disarm on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
            armed <= 1'b0;
        end else if (load) begin
            count <= load_val;
            armed <= 1'b1;
        end else if (armed && tick) begin
            if (count == '0) begin
                armed <= 1'b0;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // One step down per tick (R5)
    assert_dec_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && !load && count != '0) |=> (count == $past(count) - 1'b1));

    // A reload always takes effect and arms, even at an expiry edge (R9)
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (armed && count == $past(load_val)));

endmodule

// File: rtl/wdt_seqfeed.sv
// Module: wdt_seqfeed (top)
// Register-mapped watchdog. It holds the set-only control bits, the clamped
// limit register and the sticky expiry flag. It decodes the single-cycle
// register bus and produces the interrupt and reset-request outputs.
// Assumes one clock for bus and counter, and a word-aligned bus_addr.
module wdt_seqfeed
    import wdt_seqfeed_pkg::*;
#(
    parameter int          CNT_W        = 24,
    parameter int          PRESC_DIV    = 4,
    parameter int          LIMIT_MIN    = 255,
    parameter int          ADDR_W       = 4,
    parameter int          DATA_W       = 32,
    parameter logic [7:0]  MAGIC_FIRST  = 8'hAA,
    parameter logic [7:0]  MAGIC_SECOND = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_timeout,
    output logic              sys_reset_req
);

    localparam int            IDX_LSB   = 2;
    localparam logic [CNT_W-1:0] LIMIT_FLOOR = CNT_W'(LIMIT_MIN);

    wdt_reg_e          reg_idx;
    logic              wr_ctrl, wr_limit, wr_serve;
    logic              run_en_q, rst_en_q, expired_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  wr_limit_val;
    logic              seq_ok, seq_bad;
    logic              load, tick, expire, armed;
    logic [CNT_W-1:0]  count;
    logic              reset_fire;

    // Decode the register index and write strobes
    always_comb begin
        reg_idx  = wdt_reg_e'(bus_addr[IDX_LSB +: 2]);
        wr_ctrl  = bus_req && bus_wr && (reg_idx == REG_CTRL);
        wr_limit = bus_req && bus_wr && (reg_idx == REG_LIMIT);
        wr_serve = bus_req && bus_wr && (reg_idx == REG_SERVE);
    end

    // Clamp a limit write to the legal floor
    always_comb begin
        wr_limit_val = bus_wdata[CNT_W-1:0];
        if (wr_limit_val < LIMIT_FLOOR) begin
            wr_limit_val = LIMIT_FLOOR;
        end
    end

    // Service sequence tracker
    wdt_feed_seq #(
        .MAGIC_W      (8),
        .MAGIC_FIRST  (MAGIC_FIRST),
        .MAGIC_SECOND (MAGIC_SECOND)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_serve),
        .wr_val  (bus_wdata[7:0]),
        .seq_ok  (seq_ok),
        .seq_bad (seq_bad)
    );

    // A valid service reloads only when running
    assign load = seq_ok && run_en_q;

    // Fixed divider feeding the counter
    wdt_prescaler #(
        .DIV (PRESC_DIV)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (armed),
        .restart (load),
        .tick    (tick)
    );

    // Timeout counter
    wdt_countdown #(
        .W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (limit_q),
        .tick     (tick),
        .count    (count),
        .armed    (armed),
        .expire   (expire)
    );

    // Set-only control bits and the sticky expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en_q  <= 1'b0;
            rst_en_q  <= 1'b0;
            expired_q <= 1'b0;
        end else begin
            if (wr_ctrl && bus_wdata[CTRL_RUN_BIT]) begin
                run_en_q <= 1'b1;
            end
            if (wr_ctrl && bus_wdata[CTRL_RSTEN_BIT]) begin
                rst_en_q <= 1'b1;
            end
            if (expire) begin
                expired_q <= 1'b1;
            end
        end
    end

    // Limit register with its floor applied at write time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '1;
        end else if (wr_limit) begin
            limit_q <= wr_limit_val;
        end
    end

    // Reset is asked for on expiry or on a broken service sequence
    assign reset_fire = rst_en_q && (expire || (seq_bad && run_en_q));

    // Register the one-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_reset_req <= 1'b0;
        end else begin
            sys_reset_req <= reset_fire;
        end
    end

    assign irq_timeout = expired_q;

    // Same-cycle read mux, zero when not reading
    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_wr) begin
            case (reg_idx)
                REG_CTRL: begin
                    bus_rdata[CTRL_RUN_BIT]     = run_en_q;
                    bus_rdata[CTRL_RSTEN_BIT]   = rst_en_q;
                    bus_rdata[CTRL_EXPIRED_BIT] = expired_q;
                    bus_rdata[CTRL_ARMED_BIT]   = armed;
                end
                REG_LIMIT: bus_rdata[CNT_W-1:0] = limit_q;
                REG_COUNT: bus_rdata[CNT_W-1:0] = count;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Control bits never clear outside reset (R3)
    assert_run_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_en_q |=> run_en_q);
    assert_rsten_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_en_q |=> rst_en_q);

    // Stored limit never drops under the floor (R2)
    assert_limit_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_limit |=> (limit_q >= LIMIT_FLOOR));

    // Expiry raises a flag that then holds (R6)
    assert_expiry_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (irq_timeout && !armed));
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |=> irq_timeout);

    // Expiry with reset enabled requests reset (R7)
    assert_expiry_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rst_en_q) |=> sys_reset_req);

    // Broken sequence while guarded requests reset without reload (R8)
    assert_bad_seq_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_bad && run_en_q && rst_en_q) |=> sys_reset_req);

endmodule

// File: tb/wdt_seqfeed_tb_top.sv
`timescale 1ns/1ps
module wdt_seqfeed_tb_top;

    localparam logic [3:0] A_CTRL  = 4'h0;
    localparam logic [3:0] A_LIMIT = 4'h4;
    localparam logic [3:0] A_SERVE = 4'h8;
    localparam logic [3:0] A_COUNT = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_timeout;
    logic        sys_reset_req;

    int n_run = 0;
    int n_fail = 0;
    int pulses = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    wdt_seqfeed dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (bus_req),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_timeout   (irq_timeout),
        .sys_reset_req (sys_reset_req)
    );

    // Count reset-request cycles away from the active edge
    always @(negedge clk) if (rst_n && sys_reset_req) pulses++;

    function automatic logic [31:0] clamp_limit(input logic [31:0] raw);
        logic [31:0] v;
        v = raw & 32'h00FF_FFFF;
        return (v < 32'hFF) ? 32'hFF : v;
    endfunction

    function automatic logic [31:0] count_after(input logic [31:0] lim, input int k);
        return lim - 32'(k / 4);
    endfunction

    function automatic int expiry_edges(input logic [31:0] lim);
        return 4 * (int'(lim) + 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    // Read at the current (negedge) moment
    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic serve(input logic [7:0] b1, input logic [7:0] b2);
        bus_write(A_SERVE, {24'h0, b1});
        bus_write(A_SERVE, {24'h0, b2});
    endtask

    task automatic wait_k(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int p0;
        void'($urandom(32'd5150));
        do_reset();

        // R1 reset state
        @(negedge clk);
        bus_read(A_CTRL, rd);  check("R1 ctrl", rd, 32'h0);
        bus_read(A_LIMIT, rd); check("R1 limit", rd, 32'hFF_FFFF);
        bus_read(A_COUNT, rd); check("R1 count", rd, 32'hFF_FFFF);
        check("R1 outputs", {30'h0, irq_timeout, sys_reset_req}, 32'h0);

        // R2 clamp and truncation
        bus_write(A_LIMIT, 32'h10);
        @(negedge clk); bus_read(A_LIMIT, rd); check("R2 clamp", rd, clamp_limit(32'h10));
        bus_write(A_LIMIT, 32'h0123_4567);
        @(negedge clk); bus_read(A_LIMIT, rd); check("R2 trunc", rd, 32'h23_4567);
        bus_write(A_LIMIT, 32'h100);

        // R4 valid service without run enable does nothing
        serve(8'hAA, 8'h55);
        @(negedge clk);
        bus_read(A_COUNT, rd); check("R4 idle count", rd, 32'hFF_FFFF);
        bus_read(A_CTRL, rd);  check("R4 idle ctrl", rd, 32'h0);

        // R10 counter write ignored, idle read data zero
        bus_write(A_COUNT, 32'h0);
        @(negedge clk);
        bus_read(A_COUNT, rd); check("R10 count ro", rd, 32'hFF_FFFF);
        #1 check("R10 rdata idle", bus_rdata, 32'h0);

        // R3 set-only control bits
        bus_write(A_CTRL, 32'h1);
        bus_write(A_CTRL, 32'h0);
        @(negedge clk); bus_read(A_CTRL, rd); check("R3 run stays", rd, 32'h1);

        // R8 stray byte while idle ignored; broken sequence without reset enable
        p0 = pulses;
        bus_write(A_SERVE, 32'h12);
        serve(8'hAA, 8'h33);
        @(negedge clk);
        bus_read(A_COUNT, rd); check("R8 no reload", rd, 32'hFF_FFFF);
        check("R8 no pulse unguarded", 32'(pulses - p0), 32'h0);

        // R4/R5 valid service and decrement timing
        serve(8'hAA, 8'h55);
        @(negedge clk);
        bus_read(A_COUNT, rd); check("R4 reload", rd, 32'h100);
        bus_read(A_CTRL, rd);  check("R4 armed", rd, 32'h9);
        wait_k(2);  bus_read(A_COUNT, rd); check("R5 k=3", rd, count_after(32'h100, 3));
        wait_k(0);
        @(posedge clk); @(negedge clk);
        bus_read(A_COUNT, rd); check("R5 k=4", rd, count_after(32'h100, 4));

        // R3/R8 broken sequence with reset enable
        bus_write(A_CTRL, 32'h2);
        @(negedge clk); bus_read(A_CTRL, rd); check("R3 both set", rd, 32'hB);
        p0 = pulses;
        serve(8'hAA, 8'hAA);
        @(negedge clk);
        check("R8 reset now", {31'h0, sys_reset_req}, 32'h1);
        @(negedge clk);
        check("R8 one cycle", {31'h0, sys_reset_req}, 32'h0);
        check("R8 pulse count", 32'(pulses - p0), 32'h1);
        bus_read(A_COUNT, rd); check("R8 no reload", {31'h0, rd < 32'h100}, 32'h1);

        // R6/R7 exact expiry with reset enabled
        bus_write(A_LIMIT, 32'hFF);
        serve(8'hAA, 8'h55);
        wait_k(expiry_edges(32'hFF) - 1);
        check("R6 not yet", {30'h0, irq_timeout, sys_reset_req}, 32'h0);
        bus_read(A_COUNT, rd); check("R6 at zero", rd, 32'h0);
        wait_k(1);
        check("R6 expired", {30'h0, irq_timeout, sys_reset_req}, 32'h3);
        bus_read(A_CTRL, rd); check("R6 ctrl", rd, 32'h7);
        wait_k(1);
        check("R7 one cycle", {31'h0, sys_reset_req}, 32'h0);
        wait_k(20);
        check("R6 sticky", {31'h0, irq_timeout}, 32'h1);
        bus_read(A_COUNT, rd); check("R6 holds zero", rd, 32'h0);

        // R7 expiry without reset enable gives no request
        do_reset();
        bus_write(A_CTRL, 32'h1);
        bus_write(A_LIMIT, 32'h0);
        p0 = pulses;
        serve(8'hAA, 8'h55);
        wait_k(expiry_edges(32'hFF));
        check("R7 flag only", {30'h0, irq_timeout, sys_reset_req}, 32'h2);
        check("R7 no pulse", 32'(pulses - p0), 32'h0);

        // R9 service lands on the expiry edge
        do_reset();
        bus_write(A_CTRL, 32'h3);
        bus_write(A_LIMIT, 32'hFF);
        p0 = pulses;
        serve(8'hAA, 8'h55);
        repeat (expiry_edges(32'hFF) - 2) @(posedge clk);
        serve(8'hAA, 8'h55);
        @(negedge clk);
        check("R9 no expiry", {30'h0, irq_timeout, sys_reset_req}, 32'h0);
        bus_read(A_COUNT, rd); check("R9 reloaded", rd, 32'hFF);
        check("R9 no pulse", 32'(pulses - p0), 32'h0);
        wait_k(expiry_edges(32'hFF) - 1);
        check("R9 next not yet", {31'h0, irq_timeout}, 32'h0);
        wait_k(1);
        check("R9 next expiry", {31'h0, irq_timeout}, 32'h1);

        // R5/R2 random limits, stray bytes and sample points
        do_reset();
        bus_write(A_CTRL, 32'h1);
        for (int t = 0; t < 24; t++) begin
            logic [31:0] raw, lim;
            logic [7:0]  stray;
            int k;
            raw = $urandom_range(0, 400);
            lim = clamp_limit(raw);
            stray = 8'($urandom_range(0, 255));
            if (stray == 8'hAA) stray = 8'h00;
            bus_write(A_LIMIT, raw);
            bus_write(A_SERVE, {24'h0, stray});
            serve(8'hAA, 8'h55);
            k = $urandom_range(0, expiry_edges(lim) - 1);
            wait_k(k);
            bus_read(A_COUNT, rd); check("R5 random count", rd, count_after(lim, k));
            bus_read(A_CTRL, rd);  check("R4 random armed", rd, 32'h9);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule